// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is the logic core of a ten-output registered logic device. It holds 132 rows of 44 configuration bits. Each row forms one product term over the true and complement forms of 22 array inputs. The inputs are the dedicated inputs plus the feedback from the output cells. Configuration is written one whole row per clock edge through a small write port. The array inputs are then evaluated combinationally. The block produces ten OR-ed sum terms, ten output-enable terms, one term that clears all output registers asynchronously and one term that sets them on the next clock edge.

The rows follow a fixed layout that the surrounding output cells depend on. The register-clear term is the first row and the register-set term is the last row. The ten output groups lie between them. Each group starts with its enable row, followed by its logic rows. Group sizes grow from the two ends towards the middle, from 8 up to 16 logic rows, in steps of 2. The output cells and pin drivers sit outside this block.

Top module: `pal_sop_array`

## Requirements
- R1: While reset is asserted, every configuration bit reads as 1, which is the erased state. The outputs are then sum_out = 0, oe_out = all ones, ar_out = 1 and sp_out = 1.
- R2: A write with cfg_we = 1 and cfg_row below 132 replaces all 44 bits of that row at the rising clock edge. Bit c of cfg_fuses is column c. The new contents take effect on the outputs right after that edge.
- R3: A write with cfg_row of 132 or above changes nothing, and no output moves as a result.
- R4: Column 2k is the true form of sig_in[k] and column 2k+1 is its complement. A configuration bit of 0 connects its literal. A product term is the AND of all connected literals, so a row that is all 1 evaluates to 1.
- R5: A row that is all 0 contains both forms of every input and always evaluates to 0.
- R6: Row 0 drives ar_out and row 131 drives sp_out, each as a single product term.
- R7: Output group g starts at row 1 + sum over j<g of (S_j + 1), where S = 8, 10, 12, 14, 16, 16, 14, 12, 10, 8. The first row of the group drives oe_out[g]. The next S_g rows are its logic terms.
- R8: sum_out[g] is the OR of the connected logic rows of group g. A row that is all 1 takes no part in the OR. The output follows sig_in in the same cycle, with no register on the path.
- R9: Writing a group's enable row, row 0 or row 131 never changes any sum_out bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration write clock |
| rst_n | input | 1 | Asynchronous active-low reset; erases all rows |
| cfg_we | input | 1 | Row write strobe |
| cfg_row | input | 8 | Row index to write |
| cfg_fuses | input | 44 | New row contents; bit c is column c |
| sig_in | input | 22 | Array inputs: dedicated inputs and feedback |
| sum_out | output | 10 | Sum term of each output group |
| oe_out | output | 10 | Output-enable term of each group |
| ar_out | output | 1 | Shared asynchronous register-clear term |
| sp_out | output | 1 | Shared synchronous register-set term |

## Verification
Every configuration is tried with the all-zero and all-one input words, a walking one, a walking zero and a set of arithmetically generated words. The walking patterns separate a true-literal connection from a complement connection on each input. They also show which input a row has captured, so a misplaced column or a swapped polarity becomes visible. Each group's first and last logic rows, its enable row, and both shared rows are programmed with literals on different inputs. A group start or size that is off by one therefore moves a literal into a neighbouring output or into the enable. All-zero rows, rows erased back to all ones, and writes to rows past the end check that contradictory terms stay low, that disconnected rows drop out of the OR, and that out-of-range writes leave every output in place.

// File: rtl/pal_sop_pkg.sv
package pal_sop_pkg;

   // Logic rows in output group g: smallest at both ends, growing toward the centre
   function automatic int grp_terms(input int g, input int n_out, input int base, input int step);
      int d;
      d = (g < (n_out - 1 - g)) ? g : (n_out - 1 - g);
      return base + step * d;
   endfunction

   // First row (the enable row) of output group g; row 0 is the shared clear term
   function automatic int grp_start(input int g, input int n_out, input int base, input int step);
      int s;
      s = 1;
      for (int j = 0; j < g; j++) s += grp_terms(j, n_out, base, step) + 1;
      return s;
   endfunction

   // Total rows: clear row, all groups with their enable rows, then the shared set row
   function automatic int total_rows(input int n_out, input int base, input int step);
      return grp_start(n_out, n_out, base, step) + 1;
   endfunction

   // Largest group size
   function automatic int max_terms(input int n_out, input int base, input int step);
      int m;
      m = 0;
      for (int j = 0; j < n_out; j++)
         if (grp_terms(j, n_out, base, step) > m) m = grp_terms(j, n_out, base, step);
      return m;
   endfunction

endpackage

// File: rtl/pal_literal_map.sv
module pal_literal_map #(
   parameter int N_IN = 22,
   localparam int N_COL = 2 * N_IN
) (
   input  logic [N_IN-1:0]  sig_i,
   output logic [N_COL-1:0] lit_o
);

   // Even column carries the true form and odd column the complement
   for (genvar k = 0; k < N_IN; k++) begin : g_lit
      assign lit_o[2*k]   = sig_i[k];
      assign lit_o[2*k+1] = ~sig_i[k];
   end

endmodule

// File: rtl/pal_fuse_store.sv
module pal_fuse_store #(
   parameter int N_ROWS = 132,
   parameter int N_COL  = 44,
   parameter int ROW_AW = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [ROW_AW-1:0]                wr_row,
   input  logic [N_COL-1:0]                 wr_bits,
   output logic [N_ROWS-1:0][N_COL-1:0]     rows_q
);

   // One decoded enable per row; indices past the last row match no row
   for (genvar r = 0; r < N_ROWS; r++) begin : g_row
      logic hit;
      assign hit = wr_en && (wr_row == ROW_AW'(r));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   rows_q[r] <= '1;
         else if (hit) rows_q[r] <= wr_bits;
      end
   end

   // R2
   write_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (int'(wr_row) < N_ROWS)) |=> (rows_q[$past(wr_row)] == $past(wr_bits)));

endmodule

// File: rtl/pal_product_term.sv
module pal_product_term #(
   parameter int N_COL = 44
) (
   input  logic [N_COL-1:0] lit_i,
   input  logic [N_COL-1:0] fuse_i,
   output logic             pt_o
);

   // A bit of 1 masks its literal out of the AND
   assign pt_o = &(lit_i | fuse_i);

   // R5
   always_comb begin
      if (fuse_i == '0) begin
         zero_row_chk: assert (pt_o == 1'b0);
      end
   end

endmodule

// File: rtl/pal_sum_group.sv
module pal_sum_group #(
   parameter int N_TERMS = 8,
   parameter int N_COL   = 44
) (
   input  logic [N_TERMS-1:0]              pt_i,
   input  logic [N_TERMS-1:0][N_COL-1:0]   fuse_i,
   output logic                            sum_o
);

   logic [N_TERMS-1:0] live;

   // A fully erased row is disconnected from the OR
   for (genvar t = 0; t < N_TERMS; t++) begin : g_live
      assign live[t] = ~&fuse_i[t];
   end

   assign sum_o = |(pt_i & live);

endmodule

// File: rtl/pal_sop_array.sv
module pal_sop_array #(
   parameter int N_IN       = 22,
   parameter int N_OUT      = 10,
   parameter int TERM_BASE  = 8,
   parameter int TERM_STEP  = 2,
   parameter int ROW_AW     = 8,
   localparam int N_COL     = 2 * N_IN,
   localparam int N_ROWS    = pal_sop_pkg::total_rows(N_OUT, TERM_BASE, TERM_STEP),
   localparam int SET_ROW   = N_ROWS - 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [ROW_AW-1:0]   cfg_row,
   input  logic [N_COL-1:0]    cfg_fuses,
   input  logic [N_IN-1:0]     sig_in,
   output logic [N_OUT-1:0]    sum_out,
   output logic [N_OUT-1:0]    oe_out,
   output logic                ar_out,
   output logic                sp_out
);

   // Elaboration-time parameter checks
   if (N_IN < 1) begin : g_bad_in
      $error("pal_sop_array: N_IN must be at least 1");
   end
   if (N_OUT < 1) begin : g_bad_out
      $error("pal_sop_array: N_OUT must be at least 1");
   end
   if (TERM_BASE < 1 || TERM_STEP < 0) begin : g_bad_terms
      $error("pal_sop_array: group sizes must be positive");
   end
   if (N_ROWS > (1 << ROW_AW)) begin : g_bad_aw
      $error("pal_sop_array: ROW_AW too narrow for the row count");
   end

   logic [N_COL-1:0]              lit;
   logic [N_ROWS-1:0][N_COL-1:0]  rows_q;
   logic [N_ROWS-1:0]             pt_all;

   pal_literal_map #(.N_IN(N_IN)) u_lit (
      .sig_i (sig_in),
      .lit_o (lit)
   );

   pal_fuse_store #(.N_ROWS(N_ROWS), .N_COL(N_COL), .ROW_AW(ROW_AW)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_row  (cfg_row),
      .wr_bits (cfg_fuses),
      .rows_q  (rows_q)
   );

   for (genvar r = 0; r < N_ROWS; r++) begin : g_pt
      pal_product_term #(.N_COL(N_COL)) u_pt (
         .lit_i  (lit),
         .fuse_i (rows_q[r]),
         .pt_o   (pt_all[r])
      );
   end

   // Shared rows at both ends of the map
   assign ar_out = pt_all[0];
   assign sp_out = pt_all[SET_ROW];

   for (genvar g = 0; g < N_OUT; g++) begin : g_grp
      localparam int ST = pal_sop_pkg::grp_start(g, N_OUT, TERM_BASE, TERM_STEP);
      localparam int NT = pal_sop_pkg::grp_terms(g, N_OUT, TERM_BASE, TERM_STEP);

      assign oe_out[g] = pt_all[ST];

      pal_sum_group #(.N_TERMS(NT), .N_COL(N_COL)) u_sum (
         .pt_i   (pt_all[ST+1 +: NT]),
         .fuse_i (rows_q[ST+1 +: NT]),
         .sum_o  (sum_out[g])
      );

      // R9
      oe_row_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_we && (int'(cfg_row) == ST)) ##1 $stable(sig_in) |-> $stable(sum_out));
   end

   // R9
   shared_row_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && (int'(cfg_row) == 0 || int'(cfg_row) == SET_ROW)) ##1 $stable(sig_in)
      |-> $stable(sum_out));

   // R3
   ignore_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_we || int'(cfg_row) >= N_ROWS) ##1 $stable(sig_in)
      |-> $stable({sum_out, oe_out, ar_out, sp_out}));

endmodule

// File: tb/tb_pal_sop_array.sv
module tb_pal_sop_array;

   localparam int NI = 22;
   localparam int NO = 10;
   localparam int NC = 44;
   localparam int NR = 132;

   logic            clk = 1'b0;
   logic            rst_n = 1'b1;
   logic            cfg_we = 1'b0;
   logic [7:0]      cfg_row = '0;
   logic [NC-1:0]   cfg_fuses = '0;
   logic [NI-1:0]   sig_in = '0;
   logic [NO-1:0]   sum_out, oe_out;
   logic            ar_out, sp_out;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [NC-1:0] mf [NR];

   always #2 clk = ~clk;

   pal_sop_array dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_row(cfg_row),
      .cfg_fuses(cfg_fuses), .sig_in(sig_in), .sum_out(sum_out),
      .oe_out(oe_out), .ar_out(ar_out), .sp_out(sp_out)
   );

   function automatic int gsize(int g);
      int d = (g < NO - 1 - g) ? g : NO - 1 - g;
      return 8 + 2 * d;
   endfunction

   function automatic int gstart(int g);
      int s = 1;
      for (int j = 0; j < g; j++) s += gsize(j) + 1;
      return s;
   endfunction

   function automatic logic row_val(int r, logic [NI-1:0] s);
      logic p = 1'b1;
      for (int c = 0; c < NC; c++)
         if (!mf[r][c]) p &= (c % 2 == 0) ? s[c/2] : ~s[c/2];
      return p;
   endfunction

   function automatic logic row_live(int r);
      return !(&mf[r]);
   endfunction

   task automatic compare(string tag);
      logic [NO-1:0] es, eo;
      logic ea, ep;
      for (int g = 0; g < NO; g++) begin
         eo[g] = row_val(gstart(g), sig_in);
         es[g] = 1'b0;
         for (int t = 1; t <= gsize(g); t++)
            if (row_live(gstart(g) + t) && row_val(gstart(g) + t, sig_in)) es[g] = 1'b1;
      end
      ea = row_val(0, sig_in);
      ep = row_val(NR - 1, sig_in);
      checks++;
      if (sum_out !== es || oe_out !== eo || ar_out !== ea || sp_out !== ep) begin
         errors++;
         $display("FAIL %s sig=%h got sum=%h oe=%h ar=%b sp=%b exp sum=%h oe=%h ar=%b sp=%b",
                  tag, sig_in, sum_out, oe_out, ar_out, sp_out, es, eo, ea, ep);
      end
   endtask

   task automatic wr(int r, logic [NC-1:0] bits);
      @(negedge clk);
      cfg_we = 1'b1; cfg_row = 8'(r); cfg_fuses = bits;
      @(negedge clk);
      cfg_we = 1'b0;
      if (r < NR) mf[r] = bits;
   endtask

   function automatic logic [NC-1:0] one_lit(int k, bit inv);
      logic [NC-1:0] v = '1;
      v[2*k + (inv ? 1 : 0)] = 1'b0;
      return v;
   endfunction

   task automatic apply(logic [NI-1:0] s, string tag);
      @(negedge clk);
      sig_in = s;
      #1 compare(tag);
   endtask

   task automatic sweep(string tag);
      logic [31:0] x = 32'h1234_5678;
      apply('0, tag);
      apply('1, tag);
      for (int k = 0; k < NI; k++) apply(NI'(1) << k, tag);
      for (int k = 0; k < NI; k++) apply(~(NI'(1) << k), tag);
      for (int i = 0; i < 16; i++) begin
         x = x * 32'd1103515245 + 32'd12345;
         apply(x[29:8], tag);
      end
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int r = 0; r < NR; r++) mf[r] = '1;
      #1 rst_n = 1'b0;
      #1 compare("R1 reset erased outputs");
      sweep("R1 erased array");
      @(negedge clk) rst_n = 1'b1;

      // R6 shared rows: clear = s0 & ~s1, set = s2
      begin
         logic [NC-1:0] v = one_lit(0, 0);
         v[3] = 1'b0;
         wr(0, v);
      end
      wr(NR - 1, one_lit(2, 0));
      sweep("R6 clear/set rows");

      // R7 R8 R4: first logic row true literal, last logic row complement literal
      for (int g = 0; g < NO; g++) begin
         wr(gstart(g) + 1, one_lit(g, 0));
         wr(gstart(g) + gsize(g), one_lit(g + 10, 1));
      end
      sweep("R7 R8 R4 group layout and literals");

      // R9 enable rows programmed, sums must not move
      for (int g = 0; g < NO; g++) wr(gstart(g), one_lit((g + 1) % NI, 1));
      sweep("R9 enable rows");

      // R5 all-zero rows inside groups contribute nothing
      for (int g = 0; g < NO; g += 3) wr(gstart(g) + 2, '0);
      sweep("R5 contradictory rows");

      // R3 out-of-range writes ignored
      for (int r = NR; r < 256; r += 7) wr(r, '0);
      wr(255, '0);
      sweep("R3 out-of-range writes");

      // R2 overwrite: erase a literal row, move a literal to another row
      wr(gstart(4) + 1, '1);
      wr(gstart(4) + 9, one_lit(21, 0));
      wr(0, '1);
      sweep("R2 row rewrite");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule